// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Anode Drive Controller

This block turns per-channel pulse-width codes and current codes into a three-state drive command for each of a parameterised number of display anode channels. Every channel receives one of three commands: constant-current on, actively pulled low, or released to high impedance. The analog stage further down uses the command to switch its current source and pull-down.

A single period counter is shared by all channels. It advances once for each rising edge of a separate pulse clock, which is first brought into the system clock domain. The counter is cleared by a line pulse and stops at its maximum value. Each channel stays on while the count is below its pulse-width code. After that it goes to an off state. Two select inputs choose the off state: one applies to channels with a non-zero code and one to channels whose code is zero. Global inputs can place every channel in high impedance, force every channel on, or force every channel low. A separate monitor raises a flag when the configuration strobe rises while the high-impedance enable and the force-low input are at different levels.

Top module: `anode_pwm_ctrl`

## Requirements
- R1: The period counter advances by one for each rising edge of `pulse_clk`, at most SYNC_STAGES+2 system clock cycles after that edge. It holds at 2**PW_BITS-1 (15 by default) until the next line pulse.
- R2: While `line_pulse` is high, the counter is cleared to zero and every channel shows its off state.
- R3: A channel is on while the count is below its pulse-width code. It is no longer on once the count equals the code. A channel with code 0 is never on unless the force-on override is active.
- R4: A channel with a non-zero pulse-width code uses `off_hiz` for its off state: 1 gives high impedance and 0 gives low.
- R5: A channel whose pulse-width code is zero uses `zero_hiz` for its off state: 1 gives high impedance and 0 gives low.
- R6: A channel whose current code is zero shows its off state whenever it would otherwise be on.
- R7: When `hz_en` is low, every channel is high impedance. This overrides every other input.
- R8: When `hz_en` is high and `force_on` is high, every channel is on. This overrides `force_low`.
- R9: When `hz_en` is high, `force_on` is low and `force_low` is high, every channel is low.
- R10: While `rst_n` is low, every channel is high impedance and the counter is held at zero.
- R11: A rising edge of `strobe` while `hz_en` and `force_low` differ makes `strobe_err` high for exactly one cycle, in the cycle after the edge is sampled. In all other cycles `strobe_err` is low.
- R12: Each channel's 2-bit field in `drive_o` (bits 2i+1:2i for channel i) is 00 for high impedance, 01 for low and 10 for on. The value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_clk | input | 1 | Pulse clock; each rising edge advances the period count |
| line_pulse | input | 1 | Clears the count and places all channels in their off state |
| hz_en | input | 1 | Low releases every channel to high impedance |
| force_on | input | 1 | Forces every channel on when `hz_en` is high |
| force_low | input | 1 | Forces every channel low |
| off_hiz | input | 1 | Off state for channels with a non-zero code (1 = high impedance, 0 = low) |
| zero_hiz | input | 1 | Off state for channels with a zero code (1 = high impedance, 0 = low) |
| strobe | input | 1 | Configuration strobe, monitored for an illegal rise |
| pw_codes | input | NUM_CH*PW_BITS | Pulse-width code of channel i at bits PW_BITS*i+PW_BITS-1 : PW_BITS*i |
| cur_codes | input | NUM_CH*CUR_BITS | Current code of channel i at bits CUR_BITS*i+CUR_BITS-1 : CUR_BITS*i |
| drive_o | output | NUM_CH*2 | Per-channel drive command |
| strobe_err | output | 1 | One-cycle flag for a strobe rise under mismatched controls |

## Verification
Two cases can land on the same cycle. A line pulse can coincide with a synchronised pulse-clock edge, and global overrides can change in the very window where a channel's count reaches its code. The bench provokes both by random interleaving of pulses, line pulses, override changes and code changes. After every action it compares each channel against a reference model that counts pulses itself, saturates the count and clears it on a line pulse. Directed sequences also drive the count to saturation and past the largest code. They raise the strobe under every combination of `hz_en` and `force_low`, and each case is judged by the value expected at the ports.

// File: rtl/anode_pwm_pkg.sv
package anode_pwm_pkg;
   typedef logic [1:0] drive_t;
   localparam drive_t DRV_HIZ = 2'b00;
   localparam drive_t DRV_LOW = 2'b01;
   localparam drive_t DRV_ON  = 2'b10;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
   parameter int CNT_BITS    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pulse_clk,
   input  logic                line_clr,
   output logic [CNT_BITS-1:0] count
);
   localparam logic [CNT_BITS-1:0] CNT_MAX = {CNT_BITS{1'b1}};

   if (CNT_BITS < 1) begin : g_bad_width
      $error("pwm_period_counter: CNT_BITS must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("pwm_period_counter: SYNC_STAGES must be 0 to 4");
   end

   logic pclk_s;
   logic pclk_prev;
   logic step;

   if (SYNC_STAGES == 0) begin : g_direct
      assign pclk_s = pulse_clk;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2+1-1:0], pulse_clk} >> 0;
      end
      assign pclk_s = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pclk_prev <= 1'b0;
      else        pclk_prev <= pclk_s;
   end
   assign step = pclk_s & ~pclk_prev;

   always_ff @(posedge clk) begin
      if (!rst_n)                      count <= '0;
      else if (line_clr)               count <= '0;
      else if (step && count != CNT_MAX) count <= count + 1'b1;
   end

   assert_line_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_clr |=> (count == '0));
   assert_saturates_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !line_clr) |=> (count == CNT_MAX));
   assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_clr && count != CNT_MAX) |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/anode_channel_slot.sv
module anode_channel_slot
   import anode_pwm_pkg::*;
#(
   parameter int PW_BITS  = 4,
   parameter int CUR_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PW_BITS-1:0]  count,
   input  logic [PW_BITS-1:0]  pw_code,
   input  logic [CUR_BITS-1:0] cur_code,
   input  logic                line_act,
   input  logic                hz_en,
   input  logic                force_on,
   input  logic                force_low,
   input  logic                off_hiz,
   input  logic                zero_hiz,
   output drive_t              drive
);
   logic   in_window;
   logic   pw_zero;
   drive_t off_state;

   assign pw_zero   = (pw_code == '0);
   assign in_window = (count < pw_code) && (cur_code != '0) && !line_act;

   always_comb begin
      if (pw_zero) off_state = zero_hiz ? DRV_HIZ : DRV_LOW;
      else         off_state = off_hiz  ? DRV_HIZ : DRV_LOW;
   end

   always_comb begin
      if (!rst_n)         drive = DRV_HIZ;
      else if (!hz_en)    drive = DRV_HIZ;
      else if (force_on)  drive = DRV_ON;
      else if (force_low) drive = DRV_LOW;
      else if (in_window) drive = DRV_ON;
      else                drive = off_state;
   end

   assert_legal_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
      drive != 2'b11);
   assert_gate_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hz_en |-> drive == DRV_HIZ);
   assert_zero_never_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pw_zero && !force_on) |-> drive != DRV_ON);
   assert_line_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_act && !force_on) |-> drive != DRV_ON);
endmodule

// File: rtl/strobe_guard.sv
module strobe_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic hz_en,
   input  logic force_low,
   output logic err
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         err      <= 1'b0;
      end else begin
         strobe_q <= strobe;
         err      <= strobe & ~strobe_q & (hz_en ^ force_low);
      end
   end

   assert_flag_on_bad_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !strobe_q && (hz_en != force_low)) |=> err);
   assert_flag_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

// File: rtl/anode_pwm_ctrl.sv
module anode_pwm_ctrl
   import anode_pwm_pkg::*;
#(
   parameter int NUM_CH      = 128,
   parameter int PW_BITS     = 4,
   parameter int CUR_BITS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         pulse_clk,
   input  logic                         line_pulse,
   input  logic                         hz_en,
   input  logic                         force_on,
   input  logic                         force_low,
   input  logic                         off_hiz,
   input  logic                         zero_hiz,
   input  logic                         strobe,
   input  logic [NUM_CH*PW_BITS-1:0]    pw_codes,
   input  logic [NUM_CH*CUR_BITS-1:0]   cur_codes,
   output logic [NUM_CH*2-1:0]          drive_o,
   output logic                         strobe_err
);
   localparam int DRV_W = 2;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("anode_pwm_ctrl: NUM_CH must be at least 1");
   end
   if (CUR_BITS < 1) begin : g_bad_cur
      $error("anode_pwm_ctrl: CUR_BITS must be at least 1");
   end

   logic [PW_BITS-1:0] count;

   pwm_period_counter #(
      .CNT_BITS   (PW_BITS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_clk(pulse_clk),
      .line_clr (line_pulse),
      .count    (count)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      drive_t slot_drive;
      anode_channel_slot #(
         .PW_BITS (PW_BITS),
         .CUR_BITS(CUR_BITS)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .count    (count),
         .pw_code  (pw_codes[ch*PW_BITS +: PW_BITS]),
         .cur_code (cur_codes[ch*CUR_BITS +: CUR_BITS]),
         .line_act (line_pulse),
         .hz_en    (hz_en),
         .force_on (force_on),
         .force_low(force_low),
         .off_hiz  (off_hiz),
         .zero_hiz (zero_hiz),
         .drive    (slot_drive)
      );
      assign drive_o[ch*DRV_W +: DRV_W] = slot_drive;
   end

   strobe_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .hz_en    (hz_en),
      .force_low(force_low),
      .err      (strobe_err)
   );

   always_comb begin
      if (rst_n === 1'b0) begin
         assert_reset_hiz_R10: assert (drive_o == '0);
      end
   end

   assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hz_en && !force_on && force_low) |-> (drive_o == {NUM_CH{DRV_LOW}}));
   assert_force_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hz_en && force_on) |-> (drive_o == {NUM_CH{DRV_ON}}));
endmodule

// File: tb/anode_pwm_ctrl_test.sv
module anode_pwm_ctrl_test;
   localparam int NCH = 16;
   localparam int PWB = 4;
   localparam int CRB = 2;
   localparam int MAXC = 15;

   logic clk = 1'b0;
   logic rst_n, pulse_clk, line_pulse, hz_en, force_on, force_low;
   logic off_hiz, zero_hiz, strobe;
   logic [NCH*PWB-1:0] pw_codes;
   logic [NCH*CRB-1:0] cur_codes;
   logic [NCH*2-1:0]   drive_o;
   logic               strobe_err;

   int checks = 0;
   int errors = 0;
   int mcount = 0;

   always #5 clk = ~clk;

   anode_pwm_ctrl #(.NUM_CH(NCH), .PW_BITS(PWB), .CUR_BITS(CRB), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .pulse_clk(pulse_clk), .line_pulse(line_pulse),
      .hz_en(hz_en), .force_on(force_on), .force_low(force_low),
      .off_hiz(off_hiz), .zero_hiz(zero_hiz), .strobe(strobe),
      .pw_codes(pw_codes), .cur_codes(cur_codes),
      .drive_o(drive_o), .strobe_err(strobe_err)
   );

   function automatic logic [1:0] exp_drive(int ch);
      logic [3:0] pw = pw_codes[ch*PWB +: PWB];
      logic [1:0] cu = cur_codes[ch*CRB +: CRB];
      if (!rst_n) return 2'b00;
      if (!hz_en) return 2'b00;
      if (force_on) return 2'b10;
      if (force_low) return 2'b01;
      if (!line_pulse && cu != 0 && mcount < int'(pw)) return 2'b10;
      if (pw == 0) return zero_hiz ? 2'b00 : 2'b01;
      return off_hiz ? 2'b00 : 2'b01;
   endfunction

   task automatic check_all(string tag);
      for (int ch = 0; ch < NCH; ch++) begin
         logic [1:0] e = exp_drive(ch);
         logic [1:0] a = drive_o[ch*2 +: 2];
         checks++;
         if (a !== e) begin
            errors++;
            $display("FAIL %s ch%0d cnt=%0d actual=%b expected=%b", tag, ch, mcount, a, e);
         end
      end
   endtask

   task automatic wait_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_once();
      pulse_clk = 1'b1; wait_n(5);
      pulse_clk = 1'b0; wait_n(5);
      if (mcount < MAXC) mcount++;
   endtask

   task automatic line_once(string tag);
      line_pulse = 1'b1; wait_n(2);
      mcount = 0;
      check_all(tag);
      line_pulse = 1'b0; wait_n(1);
   endtask

   task automatic check_err(logic e, string tag);
      checks++;
      if (strobe_err !== e) begin
         errors++;
         $display("FAIL %s strobe_err actual=%b expected=%b", tag, strobe_err, e);
      end
   endtask

   task automatic strobe_case(logic hz, logic fl);
      hz_en = hz; force_low = fl; force_on = 1'b0;
      wait_n(1);
      strobe = 1'b1; wait_n(1);
      check_err(hz ^ fl, "R11 rise");
      wait_n(1);
      check_err(1'b0, "R11 hold");
      strobe = 1'b0; wait_n(1);
      check_err(1'b0, "R11 fall");
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; pulse_clk = 1'b0; line_pulse = 1'b0; hz_en = 1'b1;
      force_on = 1'b0; force_low = 1'b0; off_hiz = 1'b0; zero_hiz = 1'b1; strobe = 1'b0;
      for (int ch = 0; ch < NCH; ch++) begin
         pw_codes[ch*PWB +: PWB] = 4'(ch);
         cur_codes[ch*CRB +: CRB] = (ch % 5 == 3) ? 2'b00 : 2'b11;
      end
      wait_n(3);
      check_all("R10 reset hiz");
      pulse_once();
      check_all("R10 reset holds count");
      rst_n = 1'b1; wait_n(2);
      mcount = 0;
      check_all("R3 R5 R6 count zero");

      // R1 R3 R4: walk count to saturation and beyond
      for (int p = 0; p < 18; p++) begin
         pulse_once();
         check_all("R1 R3 R4 step");
      end
      off_hiz = 1'b1; zero_hiz = 1'b0; wait_n(1);
      check_all("R4 R5 swapped policy");
      line_once("R2 line clear");
      pulse_once(); pulse_once();
      check_all("R2 R3 after clear");
      line_pulse = 1'b1; pulse_clk = 1'b1; wait_n(6);
      mcount = 0;
      check_all("R2 line with pulse");
      line_pulse = 1'b0; pulse_clk = 1'b0; wait_n(5);
      check_all("R2 R1 edge absorbed");

      // Overrides
      force_low = 1'b1; wait_n(1); check_all("R9 force low");
      force_on = 1'b1; wait_n(1); check_all("R8 force on over low");
      hz_en = 1'b0; wait_n(1); check_all("R7 hz over force on");
      force_on = 1'b0; force_low = 1'b0; wait_n(1); check_all("R7 hz alone");
      hz_en = 1'b1; wait_n(1); check_all("R12 back to normal");

      // R11 strobe combinations
      strobe_case(1'b1, 1'b1);
      strobe_case(1'b1, 1'b0);
      strobe_case(1'b0, 1'b1);
      strobe_case(1'b0, 1'b0);
      hz_en = 1'b1; force_low = 1'b0;

      // Random mix
      for (int it = 0; it < 400; it++) begin
         int act = $urandom_range(0, 9);
         case (act)
            0, 1, 2, 3: pulse_once();
            4: line_once("R2 random line");
            5: begin
               hz_en = ($urandom_range(0, 7) != 0);
               force_on = ($urandom_range(0, 7) == 0);
               force_low = ($urandom_range(0, 5) == 0);
               wait_n(1);
            end
            6: begin off_hiz = 1'($urandom); zero_hiz = 1'($urandom); wait_n(1); end
            default: begin
               pw_codes = {$urandom, $urandom};
               cur_codes = $urandom;
               wait_n(1);
            end
         endcase
         check_all("R3 R4 R5 R6 R12 random");
      end

      rst_n = 1'b0; wait_n(2);
      mcount = 0;
      check_all("R10 late reset");
      check_err(1'b0, "R11 reset");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule